// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block watches the control strobes of an asynchronous, page-mode DRAM bus: row strobe, column strobe, write enable and output enable, all active low. It samples them with a much faster system clock and names each memory cycle from the order in which the strobe edges arrive. It never drives the bus and stores no data. It is meant for bus monitors, protocol checkers and trace logic that must label traffic generated by an external DRAM controller.

Every strobe and the multiplexed address pass through a two-stage synchronizer before any edge is detected. A row-strobe low period is opened by its falling edge. The block then follows column-strobe falls, write-enable falls and output-enable activity, and a hold counter runs during refresh periods. When the row strobe rises, the block gives one registered report with a single-cycle valid pulse. The report holds the cycle type, the row and column addresses, the number of column accesses and a violation flag.

The minimum row-strobe low time for self refresh is a parameter counted in system clocks. Edges on the bus are assumed to be at least three system clocks apart, so that each one is resolved in its own sample.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset the valid pulse is low and the type, row, column, access count and violation outputs are all zero.
- R2: Each row-strobe rise gives exactly one report. The valid pulse is high for one clock and is never asserted while the row strobe stays low.
- R3: A period with the column strobe high at the row-strobe fall and exactly one column-strobe fall, with write enable high at that fall and not falling later, reports type 0 (read). The row is the address sampled at the row-strobe fall, the column is the address sampled at the column-strobe fall, and the access count is 1.
- R4: With one column access and write enable already low at the column-strobe fall, the type is 1 (early write).
- R5: With one column access and write enable falling while the column strobe is already low, the type is 2 (late write or read-modify-write).
- R6: Two or more column-strobe falls within one row-strobe low period report type 3 (page access), whatever write enable does. The count equals the number of falls, saturating at its maximum, and the column is the last one latched.
- R7: A period with no column-strobe fall reports type 4 (row-only refresh). The row is the latched address, and the column and count are 0.
- R8: A column strobe that is already low at the row-strobe fall, without a preceding held access, reports type 5 (CAS-before-RAS refresh). The row and column are 0 whatever the address pins carry.
- R9: A column strobe kept low from an accessed period across the next row-strobe fall reports type 6 (hidden refresh) for that second period, with row and column 0. The first period is reported normally.
- R10: A CAS-before-RAS period whose row strobe stays low for at least SELF_CYCLES sampled clocks reports type 7 (self refresh) when the row strobe rises.
- R11: The violation flag is set only on a type 2 report in which output enable was low on every sample of the period. A single high sample of output enable during the period clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cyc_valid | output | 1 | One-clock pulse: report fields are valid |
| cyc_kind | output | 3 | Cycle type code (0..7, see R3 to R10) |
| cyc_row | output | ADDR_W | Latched row address |
| cyc_col | output | ADDR_W | Last latched column address |
| cyc_accesses | output | CNT_W | Column accesses in the period |
| cyc_violation | output | 1 | Late write with output enable held low |

## Verification
A wrong internal mode or flag shows up in the next report, at the first row-strobe rise after the fault, as a wrong type code, stray addresses on a refresh, or a wrong access count. A fault in the carry-over flag for a held column strobe shows up one period late: a hidden refresh is reported as a CAS-before-RAS refresh, or the other way round. A lost or doubled valid pulse gives a report that nothing expected, or leaves an expected one unmatched when the run ends.

// File: rtl/dcd_pkg.sv
// Package: shared cycle-type codes for the DRAM strobe cycle decoder.
// Assumes: the numeric values are visible at the ports and fixed by the requirements.
package dcd_pkg;

    typedef enum logic [2:0] {
        KIND_READ     = 3'd0,
        KIND_EARLY_WR = 3'd1,
        KIND_LATE_WR  = 3'd2,
        KIND_PAGE     = 3'd3,
        KIND_ROW_ONLY = 3'd4,
        KIND_CBR      = 3'd5,
        KIND_HIDDEN   = 3'd6,
        KIND_SELF     = 3'd7
    } cyc_kind_e;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_ACCESS = 2'd1,
        MODE_CBR    = 2'd2,
        MODE_HIDDEN = 2'd3
    } period_mode_e;

endpackage

// File: rtl/dcd_sync.sv
// Module: dcd_sync
// Two-stage register chain per bit. Strobes use it to settle metastability,
// and the address uses it to stay aligned with the strobes.
// Assumes: the input changes no faster than once per three clocks.
module dcd_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;

        // Shift the bit through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL;
                s2 <= RST_VAL;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end

        assign q[i] = s2;
    end

endmodule

// File: rtl/dcd_classifier.sv
// Module: dcd_classifier
// Tracks one row-strobe low period from synchronized strobes and publishes
// a registered report at the row-strobe rise.
// Assumes: inputs are already synchronized, and edges of different strobes
// fall in different samples.
module dcd_classifier
    import dcd_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int CNT_W       = 4,
    parameter int SELF_CYCLES = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras,
    input  logic              cas,
    input  logic              we,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    output logic              out_valid,
    output logic [2:0]        out_kind,
    output logic [ADDR_W-1:0] out_row,
    output logic [ADDR_W-1:0] out_col,
    output logic [CNT_W-1:0]  out_acc,
    output logic              out_viol
);

    localparam int SR_W = $clog2(SELF_CYCLES + 1);
    localparam logic [SR_W-1:0] SR_LIMIT = SR_W'(SELF_CYCLES);

    logic              ras_q, cas_q, we_q;
    logic              ras_fall, ras_rise, cas_fall, we_fall;
    period_mode_e      mode;
    logic [ADDR_W-1:0] row_r, col_r;
    logic [CNT_W-1:0]  acc_r;
    logic              early_r, late_r, oe_hi_seen, cas_held;
    logic [SR_W-1:0]   hold_cnt;
    logic              sr_hit;
    cyc_kind_e         kind_nxt;

    assign ras_fall = ras_q & ~ras;
    assign ras_rise = ~ras_q & ras;
    assign cas_fall = cas_q & ~cas;
    assign we_fall  = we_q & ~we;
    assign sr_hit   = (hold_cnt >= SR_LIMIT);

    // Keep the previous sample of each strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras;
            cas_q <= cas;
            we_q  <= we;
        end
    end

    // Period tracker: mode, addresses, access count and write-order flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MODE_IDLE;
            row_r      <= '0;
            col_r      <= '0;
            acc_r      <= '0;
            early_r    <= 1'b0;
            late_r     <= 1'b0;
            oe_hi_seen <= 1'b0;
        end else if (ras_fall) begin
            col_r      <= '0;
            acc_r      <= '0;
            early_r    <= 1'b0;
            late_r     <= 1'b0;
            oe_hi_seen <= oe;
            if (!cas) begin
                mode  <= cas_held ? MODE_HIDDEN : MODE_CBR;
                row_r <= '0;
            end else begin
                mode  <= MODE_ACCESS;
                row_r <= addr;
            end
        end else if (ras_rise) begin
            mode <= MODE_IDLE;
        end else if (mode == MODE_ACCESS) begin
            if (oe) oe_hi_seen <= 1'b1;
            if (cas_fall) begin
                col_r <= addr;
                if (acc_r != '1) acc_r <= acc_r + 1'b1;
                if (!we) early_r <= 1'b1;
            end else if (we_fall && !cas) begin
                late_r <= 1'b1;
            end
        end
    end

    // Remember a column strobe held low from an accessed period for hidden refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)                cas_held <= 1'b0;
        else if (cas)              cas_held <= 1'b0;
        else if (ras_rise)         cas_held <= (mode == MODE_ACCESS) && (acc_r != '0);
    end

    // Count sampled clocks of row strobe low during a CAS-before-RAS period.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_fall)                     hold_cnt <= '0;
        else if (mode == MODE_CBR && !ras && !sr_hit) hold_cnt <= hold_cnt + 1'b1;
    end

    // Decide the type that the current period would report.
    always_comb begin
        unique case (mode)
            MODE_CBR:    kind_nxt = sr_hit ? KIND_SELF : KIND_CBR;
            MODE_HIDDEN: kind_nxt = KIND_HIDDEN;
            default: begin
                if (acc_r == '0)                      kind_nxt = KIND_ROW_ONLY;
                else if (acc_r > CNT_W'(1))           kind_nxt = KIND_PAGE;
                else if (late_r)                      kind_nxt = KIND_LATE_WR;
                else if (early_r)                     kind_nxt = KIND_EARLY_WR;
                else                                  kind_nxt = KIND_READ;
            end
        endcase
    end

    // Publish the report register with a one-clock valid at the row-strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= '0;
            out_row   <= '0;
            out_col   <= '0;
            out_acc   <= '0;
            out_viol  <= 1'b0;
        end else begin
            out_valid <= ras_rise;
            if (ras_rise) begin
                out_kind <= kind_nxt;
                out_row  <= row_r;
                out_col  <= col_r;
                out_acc  <= acc_r;
                out_viol <= (kind_nxt == KIND_LATE_WR) && !oe_hi_seen;
            end
        end
    end

    // R2: a report lasts one clock only
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R2: every row-strobe rise is followed by a report
    a_r2_rise_reports: assert property (@(posedge clk) disable iff (!rst_n)
        ras_rise |=> out_valid);
    // R11: violation appears only with a late-write report
    a_r11_viol_late_only: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_viol) |-> (out_kind == KIND_LATE_WR));
    // R8: refresh reports carry no address
    a_r8_refresh_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind == KIND_CBR || out_kind == KIND_HIDDEN || out_kind == KIND_SELF))
        |-> (out_row == '0 && out_col == '0));
    // R6: a page report counts more than one access
    a_r6_page_count: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == KIND_PAGE) |-> (out_acc > CNT_W'(1)));

endmodule

// File: rtl/dram_cycle_decoder.sv
// Module: dram_cycle_decoder (top)
// Synchronizes the DRAM strobes and address to the system clock and
// classifies each row-strobe period into a one-clock report.
// Assumes: bus edges are at least three system clocks apart.
module dram_cycle_decoder #(
    parameter int ADDR_W      = 12,
    parameter int CNT_W       = 4,
    parameter int SELF_CYCLES = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cyc_valid,
    output logic [2:0]        cyc_kind,
    output logic [ADDR_W-1:0] cyc_row,
    output logic [ADDR_W-1:0] cyc_col,
    output logic [CNT_W-1:0]  cyc_accesses,
    output logic              cyc_violation
);

    localparam int NSTROBE = 4;

    logic [NSTROBE-1:0] strobe_s;
    logic [ADDR_W-1:0]  addr_s;

    dcd_sync #(.W(NSTROBE), .RST_VAL(1'b1)) u_strobe_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({oe_n, we_n, cas_n, ras_n}),
        .q     (strobe_s)
    );

    dcd_sync #(.W(ADDR_W), .RST_VAL(1'b0)) u_addr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (addr),
        .q     (addr_s)
    );

    dcd_classifier #(
        .ADDR_W      (ADDR_W),
        .CNT_W       (CNT_W),
        .SELF_CYCLES (SELF_CYCLES)
    ) u_classifier (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras       (strobe_s[0]),
        .cas       (strobe_s[1]),
        .we        (strobe_s[2]),
        .oe        (strobe_s[3]),
        .addr      (addr_s),
        .out_valid (cyc_valid),
        .out_kind  (cyc_kind),
        .out_row   (cyc_row),
        .out_col   (cyc_col),
        .out_acc   (cyc_accesses),
        .out_viol  (cyc_violation)
    );

endmodule

// File: tb/dram_cycle_decoder_bench.sv
module dram_cycle_decoder_bench;

    localparam int ADDR_W = 12;
    localparam int CNT_W  = 4;
    localparam int SELF_C = 40;

    typedef struct {
        logic [2:0]        kind;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [CNT_W-1:0]  acc;
        logic              viol;
        string             req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              cyc_valid, cyc_violation;
    logic [2:0]        cyc_kind;
    logic [ADDR_W-1:0] cyc_row, cyc_col;
    logic [CNT_W-1:0]  cyc_accesses;

    int checks = 0;
    int failures = 0;
    exp_t exp_q[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    dram_cycle_decoder #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SELF_CYCLES(SELF_C)) u_dram_cycle_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .cyc_row(cyc_row),
        .cyc_col(cyc_col), .cyc_accesses(cyc_accesses), .cyc_violation(cyc_violation)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n = 4);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_rep(input logic [2:0] k, input logic [ADDR_W-1:0] r, input logic [ADDR_W-1:0] c,
                              input logic [CNT_W-1:0] a, input logic v, input string req);
        exp_t e;
        e.kind = k; e.row = r; e.col = c; e.acc = a; e.viol = v; e.req = req;
        exp_q.push_back(e);
    endtask

    // One period with a single column access; wr: 0 read, 1 early, 2 late
    task automatic single_access(input logic [ADDR_W-1:0] r, input logic [ADDR_W-1:0] c, input int wr,
                                 input bit oe_pulse, input bit hold_cas);
        addr = r; step();
        ras_n = 1'b0; step();
        addr = c;
        if (wr == 1) we_n = 1'b0;
        step();
        cas_n = 1'b0; step();
        if (oe_pulse) begin oe_n = 1'b1; step(); oe_n = 1'b0; step(); end
        if (wr == 2) begin we_n = 1'b0; step(); end
        we_n = 1'b1;
        if (!hold_cas) begin cas_n = 1'b1; step(); end
        ras_n = 1'b1; step();
    endtask

    // Monitor: pop and compare each report
    always @(negedge clk) begin
        if (rst_n && cyc_valid) begin
            if (exp_q.size() == 0) begin
                check("R2", "unexpected report", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "kind", cyc_kind, e.kind);
                check(e.req, "row", cyc_row, e.row);
                check(e.req, "col", cyc_col, e.col);
                check(e.req, "accesses", cyc_accesses, e.acc);
                check(e.req, "violation", cyc_violation, e.viol);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check("WATCHDOG", "timeout", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        oe_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        check("R1", "valid", cyc_valid, 0);
        check("R1", "kind", cyc_kind, 0);
        check("R1", "row", cyc_row, 0);
        check("R1", "col", cyc_col, 0);
        check("R1", "accesses", cyc_accesses, 0);
        check("R1", "violation", cyc_violation, 0);

        // R3: read
        expect_rep(3'd0, 12'h123, 12'h045, 4'd1, 1'b0, "R3");
        single_access(12'h123, 12'h045, 0, 1'b0, 1'b0);
        // R4: early write
        expect_rep(3'd1, 12'hABC, 12'h3FF, 4'd1, 1'b0, "R4");
        single_access(12'hABC, 12'h3FF, 1, 1'b0, 1'b0);
        // R5 and R11: late write with OE held low gives violation
        expect_rep(3'd2, 12'h0F0, 12'h00F, 4'd1, 1'b1, "R5");
        single_access(12'h0F0, 12'h00F, 2, 1'b0, 1'b0);
        // R11: late write with an OE high pulse, no violation
        expect_rep(3'd2, 12'h555, 12'h2AA, 4'd1, 1'b0, "R11");
        single_access(12'h555, 12'h2AA, 2, 1'b1, 1'b0);

        // R6: page with three accesses, a late write inside
        expect_rep(3'd3, 12'h321, 12'h077, 4'd3, 1'b0, "R6");
        addr = 12'h321; step();
        ras_n = 1'b0; step();
        for (int i = 0; i < 3; i++) begin
            addr = (i == 2) ? 12'h077 : 12'(i + 5); step();
            cas_n = 1'b0; step();
            if (i == 1) begin we_n = 1'b0; step(); we_n = 1'b1; end
            cas_n = 1'b1; step();
        end
        ras_n = 1'b1; step();

        // R6: saturation at 17 accesses
        expect_rep(3'd3, 12'h010, 12'h011, 4'd15, 1'b0, "R6");
        addr = 12'h010; step();
        ras_n = 1'b0; step();
        addr = 12'h011;
        for (int i = 0; i < 17; i++) begin
            cas_n = 1'b0; step();
            cas_n = 1'b1; step();
        end
        ras_n = 1'b1; step();

        // R7: row-only refresh
        expect_rep(3'd4, 12'h7E7, 12'h000, 4'd0, 1'b0, "R7");
        addr = 12'h7E7; step();
        ras_n = 1'b0; step(); step();
        ras_n = 1'b1; step();

        // R8: CBR with busy address pins
        expect_rep(3'd5, 12'h000, 12'h000, 4'd0, 1'b0, "R8");
        addr = 12'hFFF; step();
        cas_n = 1'b0; step();
        ras_n = 1'b0; step();
        addr = 12'h9A9; step();
        ras_n = 1'b1; step();
        cas_n = 1'b1; step();

        // R9: read then hidden refresh with CAS held
        expect_rep(3'd0, 12'h444, 12'h222, 4'd1, 1'b0, "R9");
        expect_rep(3'd6, 12'h000, 12'h000, 4'd0, 1'b0, "R9");
        single_access(12'h444, 12'h222, 0, 1'b0, 1'b1);
        addr = 12'h5A5;
        ras_n = 1'b0; step(); step();
        ras_n = 1'b1; step();
        cas_n = 1'b1; step();

        // R10: self refresh with long hold
        expect_rep(3'd7, 12'h000, 12'h000, 4'd0, 1'b0, "R10");
        cas_n = 1'b0; step();
        ras_n = 1'b0; step(SELF_C + 20);
        ras_n = 1'b1; step();
        cas_n = 1'b1; step();

        // R2: long idle produces no report
        step(20);
        check("R2", "pending reports", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule